// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block is the programmable counter stage of a fractional-N feedback divider. It runs on the output clock of a 16/17 prescaler and steers that prescaler through a modulus-select output. Each output period spans P prescaler cycles. During the first S of them the prescaler divides by 17, and during the rest it divides by 16. One period therefore covers N = 16·P + S oscillator cycles.

The ratio for each period is an integer setting plus a signed offset from a sigma-delta modulator. The offset has eight levels, from −4 to +3. The block adds the two, saturates the sum to a legal range and splits it into new P and S values. It loads these only on the last cycle of a period. A single plain dual-modulus prescaler is therefore enough, even though the offset is multi-level. The one-cycle output pulse also serves as the modulator's clock enable, so the next offset is ready for the next reload.

Top module: `swallow_divider`

## Requirements
- R1: While `rst` is high, each rising edge restarts a period at its first cycle. After such an edge `div_pulse` is 0 and `mod_sel` is 1 exactly when the captured S is nonzero.
- R2: The effective ratio is `ratio_int` plus `sdm_off`. `sdm_off` is a 3-bit two's-complement value, so 3'b100 is −4 and 3'b011 is +3.
- R3: The effective ratio splits as P = N >> 4 and S = N & 15. Within a period, `mod_sel` (1 = divide by 17, 0 = divide by 16) is 1 for exactly the first S prescaler cycles and 0 for the remaining P − S.
- R4: `div_pulse` is 1 for exactly one prescaler cycle per period: the P-th cycle, the last one.
- R5: The oscillator cycles in one period, summed as 16 or 17 per prescaler cycle according to `mod_sel`, equal the effective ratio N.
- R6: `ratio_int` and `sdm_off` are sampled only at the rising edge that ends a period (or at a reset edge). Changes at any other edge do not affect the period in progress.
- R7: An effective ratio below 240 is raised to 240, which keeps P ≥ 15 ≥ S. One above 2^NW − 1 (1023 by default) is lowered to 2^NW − 1.
- R8: When S = 0 (for example N = 256), `mod_sel` stays 0 for the whole period. When S = P = 15 (N = 255), `mod_sel` stays 1 on every cycle, including the terminal one.
- R9: The first period after reset uses the ratio present at the last reset edge, even if the inputs change right after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_int | input | NW | Integer divide ratio |
| sdm_off | input | OW | Signed modulator offset, two's complement |
| mod_sel | output | 1 | Prescaler modulus select, 1 = divide by 17 |
| div_pulse | output | 1 | Divided output pulse, one prescaler cycle wide |

## Verification
Two events can land in the same prescaler cycle: the end of the swallow phase and the terminal count with its reload. This happens at N = 255, where S equals P. It is provoked by holding that ratio and then leaving it straight into N = 256 and the saturated ratios. The check is that `mod_sel` stays high through the pulse cycle and that the next period starts from freshly loaded counts. A second overlap is a new modulator offset arriving on the pulse cycle itself. The bench judges each period by accumulating 16 or 17 oscillator cycles per prescaler cycle and comparing the total with the ratio its own model loaded.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
  // prescaler divides by 2**PRE_LOG2 or 2**PRE_LOG2 + 1
  localparam int PRE_LOG2 = 4;
  localparam int PRE_DIV  = 1 << PRE_LOG2;
  localparam int S_MAX    = PRE_DIV - 1;
  // smallest ratio whose main count can always hold the largest swallow count
  localparam int MIN_RATIO = S_MAX * PRE_DIV;
endpackage

// File: rtl/ratio_fold.sv
module ratio_fold
  import swdiv_pkg::*;
#(
  parameter int NW = 10,
  parameter int OW = 3
) (
  input  logic [NW-1:0]          ratio_int,
  input  logic [OW-1:0]          sdm_off,
  output logic [NW-PRE_LOG2-1:0] p_cnt,
  output logic [PRE_LOG2-1:0]    s_cnt
);
  localparam int SW = NW + 2;
  localparam logic signed [SW-1:0] LO = SW'(MIN_RATIO);
  localparam logic signed [SW-1:0] HI = SW'((1 << NW) - 1);

  logic signed [SW-1:0] sum;
  logic [NW-1:0]        n_sat;

  always_comb begin
    sum = $signed({2'b00, ratio_int}) + $signed({{(SW-OW){sdm_off[OW-1]}}, sdm_off});
    if (sum < LO)      n_sat = NW'(MIN_RATIO);
    else if (sum > HI) n_sat = {NW{1'b1}};
    else               n_sat = sum[NW-1:0];
  end

  assign p_cnt = n_sat[NW-1:PRE_LOG2];
  assign s_cnt = n_sat[PRE_LOG2-1:0];
endmodule

// File: rtl/swallow_ctr.sv
module swallow_ctr
  import swdiv_pkg::*;
#(
  parameter int PW = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PW-1:0]       p_new,
  input  logic [PRE_LOG2-1:0] s_new,
  output logic                mod_sel,
  output logic                term
);
  logic [PW-1:0]       cnt_q, cnt_n;
  logic [PW-1:0]       p_q, p_n;
  logic [PRE_LOG2-1:0] s_q, s_n;
  logic                mod_q, term_q;
  logic                reload;

  // counts are taken only when a period closes
  assign reload = term_q;

  always_comb begin
    cnt_n = reload ? '0    : cnt_q + 1'b1;
    p_n   = reload ? p_new : p_q;
    s_n   = reload ? s_new : s_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      p_q    <= p_new;
      s_q    <= s_new;
      mod_q  <= (s_new != '0);
      term_q <= (p_new == PW'(1));
    end else begin
      cnt_q  <= cnt_n;
      p_q    <= p_n;
      s_q    <= s_n;
      mod_q  <= (cnt_n < PW'(s_n));
      term_q <= (cnt_n == p_n - 1'b1);
    end
  end

  assign mod_sel = mod_q;
  assign term    = term_q;
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swdiv_pkg::*;
#(
  parameter int NW = 10,
  parameter int OW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] ratio_int,
  input  logic [OW-1:0] sdm_off,
  output logic          mod_sel,
  output logic          div_pulse
);
  localparam int PW = NW - PRE_LOG2;

  logic [PW-1:0]       p_cnt;
  logic [PRE_LOG2-1:0] s_cnt;

  ratio_fold #(.NW(NW), .OW(OW)) i_fold (
    .ratio_int (ratio_int),
    .sdm_off   (sdm_off),
    .p_cnt     (p_cnt),
    .s_cnt     (s_cnt)
  );

  swallow_ctr #(.PW(PW)) i_ctr (
    .clk     (clk),
    .rst     (rst),
    .p_new   (p_cnt),
    .s_new   (s_cnt),
    .mod_sel (mod_sel),
    .term    (div_pulse)
  );
endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk
  import swdiv_pkg::*;
#(
  parameter int NW = 10
) (
  input logic clk,
  input logic rst,
  input logic mod_sel,
  input logic div_pulse
);
  localparam int PMIN = S_MAX;
  localparam int PMAX = (1 << (NW - PRE_LOG2)) - 1;

  logic [NW-1:0] gap;
  logic [NW-1:0] mcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= NW'(1);
      mcnt <= '0;
    end else begin
      gap  <= div_pulse ? NW'(1) : gap + 1'b1;
      mcnt <= div_pulse ? '0 : mcnt + NW'(mod_sel);
    end
  end

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  // R4
  period_len_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> (gap >= NW'(PMIN) && gap <= NW'(PMAX)));

  // R3
  swallow_order_chk: assert property (@(posedge clk) disable iff (rst)
    (!mod_sel && !div_pulse) |=> !mod_sel);

  // R3
  swallow_count_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> ((mcnt + NW'(mod_sel)) <= NW'(S_MAX) && (mcnt + NW'(mod_sel)) <= gap));
endmodule

bind swallow_divider swallow_divider_chk #(.NW(NW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .mod_sel   (mod_sel),
  .div_pulse (div_pulse)
);

// File: tb/test_swallow_divider.sv
`timescale 1ns/1ps
module test_swallow_divider;
  localparam int NW = 10;
  localparam int OW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NW-1:0] ratio_int = 10'd500;
  logic [OW-1:0] off_man = 3'd0;
  logic [OW-1:0] off_auto = 3'd0;
  logic          auto_en = 1'b0;
  logic [OW-1:0] sdm_off;
  logic          mod_sel, div_pulse;

  assign sdm_off = auto_en ? off_auto : off_man;

  swallow_divider #(.NW(NW), .OW(OW)) i_swallow_divider (
    .clk(clk), .rst(rst), .ratio_int(ratio_int), .sdm_off(sdm_off),
    .mod_sel(mod_sel), .div_pulse(div_pulse)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, auto_idx = 0, periods = 0;
  string phase = "R1";
  int m_k = 0, m_p = 1, m_s = 0, m_n = 0, vco = 0;
  bit started = 0;

  function automatic int eff_ratio(int r, logic [OW-1:0] o);
    int n;
    n = r + int'($signed(o));
    if (n < 240) n = 240;
    if (n > (1 << NW) - 1) n = (1 << NW) - 1;
    return n;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s/%s act=%0d exp=%0d (cycle %0d)", phase, tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // reference model: period position and loaded counts
  always @(posedge clk) begin
    cyc++;
    if (rst || m_k == m_p - 1) begin
      m_n = eff_ratio(int'(ratio_int), sdm_off);
      m_p = m_n / 16;
      m_s = m_n % 16;
      m_k = 0;
    end else begin
      m_k++;
    end
    started = 1;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
    end
  end

  // compare, oscillator-cycle count, modulator stepping
  always @(negedge clk) begin
    if (started) begin
      check("R3 mod_sel", int'(mod_sel), int'(m_k < m_s));
      check("R4 div_pulse", int'(div_pulse), int'(m_k == m_p - 1));
      if (rst) vco = 0;
      else begin
        vco += 16 + int'(mod_sel);
        if (div_pulse) begin
          check("R5 period length", vco, m_n);
          vco = 0;
          periods++;
          if (auto_en) begin
            auto_idx++;
            off_auto <= 3'(((auto_idx * 3 + 1) % 8) - 4);
          end
        end
      end
    end
  end

  task automatic wait_periods(int n);
    int target;
    target = periods + n;
    while (periods < target) @(negedge clk);
  endtask

  initial begin
    // R1: reset state with ratio 500 (P=31, S=4)
    repeat (3) @(negedge clk);
    check("R1 reset pulse", int'(div_pulse), 0);
    check("R1 reset mod_sel", int'(mod_sel), 1);
    // R9: inputs change on release; first period must still be 500
    phase = "R9";
    rst = 1'b0;
    ratio_int = 10'd700;
    off_man = 3'd3;
    wait_periods(2);
    // R2: modulator offsets stepped on each pulse, -4..+3
    phase = "R2";
    ratio_int = 10'd500;
    auto_en = 1'b1;
    wait_periods(40);
    // R6: inputs wiggle on every cycle, only terminal edges count
    phase = "R6";
    auto_en = 1'b0;
    for (int i = 0; i < 700; i++) begin
      off_man = 3'(i * 5 + 2);
      ratio_int = ((i / 7) % 2 == 0) ? 10'd480 : 10'd530;
      @(negedge clk);
    end
    // R7: saturation at both ends
    phase = "R7";
    ratio_int = 10'd241; off_man = 3'b100;
    wait_periods(4);
    ratio_int = 10'd0; off_man = 3'b100;
    wait_periods(3);
    ratio_int = 10'd1022; off_man = 3'b011;
    wait_periods(3);
    // R8: S=0 then S=P=15, then back out
    phase = "R8";
    ratio_int = 10'd256; off_man = 3'd0;
    wait_periods(3);
    ratio_int = 10'd255;
    wait_periods(4);
    ratio_int = 10'd256;
    wait_periods(3);
    summary();
  end
endmodule